// File: doc/BRIEF.md
# Background Fuse Check Scheduler

This block decides when the fuse array's two background checks run: the integrity check and the consistency check. Software sets it up through a small write port. It writes a watchdog limit, one period mask for each kind of check and a one-shot trigger. Two lock bits can then freeze that setup. The block issues a single-cycle start pulse to an external checker and tags it with the kind of check. It then waits for the checker's done pulse. If that pulse is late, the block raises a sticky timeout error.

A free-running pseudo-random sequence paces the periodic checks. A check of a given kind becomes due whenever the sequence value ANDed with that kind's mask is zero. While another check is in flight, a due periodic check is dropped and not queued. A trigger is different: it stays pending until it has been served.

The controller is a three-state machine:
- `ST_IDLE` waits for a launch.
- `ST_RUN` waits for done or for the watchdog.
- `ST_HALT` is terminal until reset.

It has four transitions:
- IDLE→RUN (launch)
- RUN→IDLE (done)
- RUN→HALT (watchdog expiry)
- HALT→HALT (hold)

Top module: `fuse_check_sched`

## Requirements
- R1: After reset, `chk_start`, `chk_busy` and `chk_timeout_err` are 0. The timeout and both masks read 0, both lock bits read 1, and the pacing sequence holds 1.
- R2: A timeout value of 0 disables the watchdog. A started check then waits for `chk_done` with no limit and never raises the error.
- R3: A mask of 0 disables periodic checks of that kind, so no start of that kind happens without a trigger.
- R4: The pacing sequence advances every cycle as x_next = (x >> 1) XOR (x[0] ? 8'hB8 : 0). At a rising edge in IDLE, a check of a kind is launched when mask & x is zero and the mask is nonzero. `chk_start` is then high for exactly the following cycle. `chk_kind` is 0 for integrity and 1 for consistency.
- R5: Launch priority runs in this order: pending integrity trigger, pending consistency trigger, periodic integrity, periodic consistency. Periodic opportunities that occur while a check is busy are dropped. A check ends at the edge that samples `chk_done` high, and the next launch can happen at the following edge.
- R6: Writing address 3 sets pending triggers: bit 0 for integrity, bit 1 for consistency. Each stays pending until its check is launched.
- R7: With timeout N>0, `chk_done` must be sampled high at one of the first N edges after the launch edge. Otherwise `chk_timeout_err` rises after the Nth edge. The error is sticky, and no further check starts until reset.
- R8: A periodic check uses the timeout value that was held when its mask was written. A triggered check uses the timeout value held at launch.
- R9: Address 0 holds the timeout, address 1 the integrity mask and address 2 the consistency mask. While the check lock (address 4) is 0, writes to addresses 0, 1 and 2 are ignored.
- R10: While the trigger lock (address 5) is 0, writes to address 3 are ignored.
- R11: Writing 0 to bit 0 of a lock address clears that lock. Writing 1 never sets it again. Only reset restores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_addr | input | 3 | Setup write address |
| cfg_wdata | input | DW | Setup write data |
| chk_done | input | 1 | Checker completion pulse |
| chk_start | output | 1 | One-cycle check launch pulse |
| chk_kind | output | 1 | Kind of launched check (0 integrity, 1 consistency) |
| chk_busy | output | 1 | A check is in flight |
| chk_timeout_err | output | 1 | Sticky watchdog error |
| rd_timeout | output | DW | Current timeout value |
| rd_imask | output | DW | Current integrity mask |
| rd_cmask | output | DW | Current consistency mask |
| rd_chk_lock | output | 1 | Check lock bit |
| rd_trig_lock | output | 1 | Trigger lock bit |

## Verification
The bench tracks the pacing sequence and the arbitration for every cycle over a sweep of masks, with and without triggers. A design that misordered triggers against periodic checks, or that queued dropped opportunities, would start a check in the wrong cycle or of the wrong kind. The watchdog is probed at both sides of its boundary: done on the Nth edge must pass, and silence must fail exactly there. An off-by-one counter would flag one cycle early or one cycle late. A timeout rewrite after a mask write must not affect periodic checks, so a design reading the live value would flag an error. Locked writes are checked through the readback ports, and a design that let a lock be set again would show a 1.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } fcs_state_e;

    localparam logic [2:0] ADDR_TIMEOUT = 3'd0;
    localparam logic [2:0] ADDR_IMASK   = 3'd1;
    localparam logic [2:0] ADDR_CMASK   = 3'd2;
    localparam logic [2:0] ADDR_TRIG    = 3'd3;
    localparam logic [2:0] ADDR_CLOCK   = 3'd4;
    localparam logic [2:0] ADDR_TLOCK   = 3'd5;

    localparam logic KIND_INTEG   = 1'b0;
    localparam logic KIND_CONSIST = 1'b1;
endpackage

// File: rtl/fcs_lfsr.sv
module fcs_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] SEED = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEED;
        else        q <= (q >> 1) ^ (q[0] ? TAPS : '0);
    end

    // R4: a maximal sequence never reaches zero
    assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n) q != '0);
endmodule

// File: rtl/fcs_cfg.sv
module fcs_cfg
    import fcs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    served,
    output logic [DW-1:0] timeout_q,
    output logic [DW-1:0] imask_q,
    output logic [DW-1:0] cmask_q,
    output logic [DW-1:0] isnap_q,
    output logic [DW-1:0] csnap_q,
    output logic [1:0]    pend_q,
    output logic          chk_lock_q,
    output logic          trig_lock_q
);
    logic       wr_cfg;
    logic       wr_trig;
    logic [1:0] trig_set;

    assign wr_cfg   = we && chk_lock_q;
    assign wr_trig  = we && trig_lock_q && (addr == ADDR_TRIG);
    assign trig_set = wr_trig ? wdata[1:0] : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timeout_q   <= '0;
            imask_q     <= '0;
            cmask_q     <= '0;
            isnap_q     <= '0;
            csnap_q     <= '0;
            pend_q      <= '0;
            chk_lock_q  <= 1'b1;
            trig_lock_q <= 1'b1;
        end else begin
            if (wr_cfg && addr == ADDR_TIMEOUT) timeout_q <= wdata;
            if (wr_cfg && addr == ADDR_IMASK) begin
                imask_q <= wdata;
                isnap_q <= timeout_q;
            end
            if (wr_cfg && addr == ADDR_CMASK) begin
                cmask_q <= wdata;
                csnap_q <= timeout_q;
            end
            pend_q <= (pend_q & ~served) | trig_set;
            if (we && addr == ADDR_CLOCK && !wdata[0]) chk_lock_q  <= 1'b0;
            if (we && addr == ADDR_TLOCK && !wdata[0]) trig_lock_q <= 1'b0;
        end
    end

    // R9: locked setup cannot change
    assert_locked_cfg_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_lock_q |=> ($stable(timeout_q) && $stable(imask_q) && $stable(cmask_q)));
    // R11: locks never return to 1
    assert_chk_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_lock_q |=> !chk_lock_q);
    assert_trig_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_lock_q |=> !trig_lock_q);
endmodule

// File: rtl/fuse_check_sched.sv
module fuse_check_sched
    import fcs_pkg::*;
#(
    parameter int          DW   = 8,
    parameter logic [DW-1:0] TAPS = 8'hB8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          chk_done,
    output logic          chk_start,
    output logic          chk_kind,
    output logic          chk_busy,
    output logic          chk_timeout_err,
    output logic [DW-1:0] rd_timeout,
    output logic [DW-1:0] rd_imask,
    output logic [DW-1:0] rd_cmask,
    output logic          rd_chk_lock,
    output logic          rd_trig_lock
);
    fcs_state_e    state_q, state_d;
    logic [DW-1:0] lfsr_q;
    logic [DW-1:0] isnap, csnap;
    logic [1:0]    pend;
    logic [1:0]    served;

    logic          sel_valid, sel_kind;
    logic [1:0]    sel_clr;
    logic [DW-1:0] sel_limit;
    logic [DW-1:0] limit_q, elapsed_q, elapsed_inc;
    logic          start_q, kind_q;
    logic          expire;

    fcs_lfsr #(.W(DW), .TAPS(TAPS)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .q     (lfsr_q)
    );

    fcs_cfg #(.DW(DW)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .served      (served),
        .timeout_q   (rd_timeout),
        .imask_q     (rd_imask),
        .cmask_q     (rd_cmask),
        .isnap_q     (isnap),
        .csnap_q     (csnap),
        .pend_q      (pend),
        .chk_lock_q  (rd_chk_lock),
        .trig_lock_q (rd_trig_lock)
    );

    // Launch arbitration
    always_comb begin
        sel_valid = 1'b0;
        sel_kind  = KIND_INTEG;
        sel_clr   = 2'b00;
        sel_limit = '0;
        if (pend[0]) begin
            sel_valid = 1'b1;
            sel_clr   = 2'b01;
            sel_limit = rd_timeout;
        end else if (pend[1]) begin
            sel_valid = 1'b1;
            sel_kind  = KIND_CONSIST;
            sel_clr   = 2'b10;
            sel_limit = rd_timeout;
        end else if (rd_imask != '0 && (rd_imask & lfsr_q) == '0) begin
            sel_valid = 1'b1;
            sel_limit = isnap;
        end else if (rd_cmask != '0 && (rd_cmask & lfsr_q) == '0) begin
            sel_valid = 1'b1;
            sel_kind  = KIND_CONSIST;
            sel_limit = csnap;
        end
    end

    assign served      = (state_q == ST_IDLE) ? sel_clr : 2'b00;
    assign elapsed_inc = elapsed_q + DW'(1);
    assign expire      = (limit_q != '0) && (elapsed_inc == limit_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sel_valid) state_d = ST_RUN;
            ST_RUN: begin
                if (chk_done)    state_d = ST_IDLE;
                else if (expire) state_d = ST_HALT;
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and watchdog
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q   <= 1'b0;
            kind_q    <= KIND_INTEG;
            limit_q   <= '0;
            elapsed_q <= '0;
        end else begin
            start_q <= (state_q == ST_IDLE) && sel_valid;
            if (state_q == ST_IDLE && sel_valid) begin
                kind_q    <= sel_kind;
                limit_q   <= sel_limit;
                elapsed_q <= '0;
            end else if (state_q == ST_RUN) begin
                elapsed_q <= elapsed_inc;
            end
        end
    end

    assign chk_start       = start_q;
    assign chk_kind        = kind_q;
    assign chk_busy        = (state_q == ST_RUN);
    assign chk_timeout_err = (state_q == ST_HALT);

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start |=> !chk_start);
    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start |-> chk_busy);
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_timeout_err |=> chk_timeout_err);
    assert_no_start_after_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_timeout_err |-> !chk_start);
    assert_err_from_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chk_timeout_err) |-> $past(chk_busy));
endmodule

// File: tb/fuse_check_sched_tb.sv
module fuse_check_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          chk_done;
    logic          chk_start, chk_kind, chk_busy, chk_timeout_err;
    logic [DW-1:0] rd_timeout, rd_imask, rd_cmask;
    logic          rd_chk_lock, rd_trig_lock;

    logic auto_en = 1'b0;
    logic done_auto = 1'b0;
    logic man_done = 1'b0;
    logic model_on = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    assign chk_done = auto_en ? done_auto : man_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    fuse_check_sched #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .chk_done(chk_done), .chk_start(chk_start),
        .chk_kind(chk_kind), .chk_busy(chk_busy), .chk_timeout_err(chk_timeout_err),
        .rd_timeout(rd_timeout), .rd_imask(rd_imask), .rd_cmask(rd_cmask),
        .rd_chk_lock(rd_chk_lock), .rd_trig_lock(rd_trig_lock)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected schedule from R4, R5, R6 (no locks, immediate done)
    logic [DW-1:0] m_lfsr, m_imask, m_cmask;
    logic [1:0]    m_pend;
    logic          m_busy, exp_start, exp_kind;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lfsr = 8'd1; m_imask = '0; m_cmask = '0; m_pend = '0;
            m_busy = 1'b0; exp_start = 1'b0; exp_kind = 1'b0;
        end else begin
            exp_start = 1'b0;
            if (m_busy) begin
                if (chk_done) m_busy = 1'b0;
            end else begin
                if (m_pend[0]) begin
                    exp_start = 1'b1; exp_kind = 1'b0; m_pend[0] = 1'b0;
                end else if (m_pend[1]) begin
                    exp_start = 1'b1; exp_kind = 1'b1; m_pend[1] = 1'b0;
                end else if (m_imask != 0 && (m_imask & m_lfsr) == 0) begin
                    exp_start = 1'b1; exp_kind = 1'b0;
                end else if (m_cmask != 0 && (m_cmask & m_lfsr) == 0) begin
                    exp_start = 1'b1; exp_kind = 1'b1;
                end
                if (exp_start) m_busy = 1'b1;
            end
            if (cfg_we) begin
                if (cfg_addr == 3'd1) m_imask = cfg_wdata;
                if (cfg_addr == 3'd2) m_cmask = cfg_wdata;
                if (cfg_addr == 3'd3) m_pend = m_pend | cfg_wdata[1:0];
            end
            m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 8'hB8 : 8'h00);
        end
    end

    always @(negedge clk) begin
        done_auto <= chk_start;
        if (model_on && rst_n) begin
            check("R4 R5 start", chk_start, exp_start);
            if (exp_start) check("R5 R6 kind", chk_kind, exp_kind);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; man_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_start();
        for (int i = 0; i < 100; i++) begin
            if (chk_start) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int starts;
        do_reset();
        // R1
        check("R1 start", chk_start, 0);
        check("R1 busy", chk_busy, 0);
        check("R1 err", chk_timeout_err, 0);
        check("R1 timeout", rd_timeout, 0);
        check("R1 imask", rd_imask, 0);
        check("R1 cmask", rd_cmask, 0);
        check("R1 chk_lock", rd_chk_lock, 1);
        check("R1 trig_lock", rd_trig_lock, 1);

        // R3: zero masks, no starts
        starts = 0;
        repeat (200) begin @(negedge clk); if (chk_start) starts++; end
        check("R3 no periodic start", starts, 0);

        // R4 R5 R6 sweep against the expected schedule
        model_on = 1'b1; auto_en = 1'b1;
        foreach (sweep_masks[k]) begin
            wr(3'd1, sweep_masks[k]);
            repeat (150) @(negedge clk);
            wr(3'd1, 8'h00);
            repeat (5) @(negedge clk);
        end
        foreach (sweep_masks[k]) begin
            wr(3'd2, sweep_masks[k]);
            repeat (150) @(negedge clk);
            wr(3'd2, 8'h00);
            repeat (5) @(negedge clk);
        end
        wr(3'd1, 8'h03); wr(3'd2, 8'h01);
        repeat (200) @(negedge clk);
        wr(3'd3, 8'h03);
        repeat (50) @(negedge clk);
        wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        repeat (5) @(negedge clk);
        wr(3'd3, 8'h03);
        repeat (10) @(negedge clk);
        wr(3'd3, 8'h02);
        repeat (10) @(negedge clk);
        model_on = 1'b0; auto_en = 1'b0;

        // R7: no done, timeout 5
        do_reset();
        wr(3'd0, 8'd5); wr(3'd3, 8'h01);
        wait_start();
        check("R7 start seen", chk_start, 1);
        repeat (4) @(negedge clk);
        check("R7 no err before N", chk_timeout_err, 0);
        check("R7 busy before N", chk_busy, 1);
        @(negedge clk);
        check("R7 err at N", chk_timeout_err, 1);
        wr(3'd3, 8'h02);
        starts = 0;
        repeat (50) begin @(negedge clk); if (chk_start) starts++; end
        check("R7 halted no start", starts, 0);
        check("R7 err sticky", chk_timeout_err, 1);

        // R7: done on the Nth edge passes
        do_reset();
        wr(3'd0, 8'd5); wr(3'd3, 8'h01);
        wait_start();
        repeat (4) @(negedge clk);
        man_done = 1'b1;
        @(negedge clk);
        man_done = 1'b0;
        check("R7 done at N no err", chk_timeout_err, 0);
        check("R7 done at N idle", chk_busy, 0);

        // R2: zero timeout waits forever
        do_reset();
        wr(3'd3, 8'h01);
        repeat (300) @(negedge clk);
        check("R2 still busy", chk_busy, 1);
        check("R2 no err", chk_timeout_err, 0);

        // R8: periodic keeps snapshot 0 despite later timeout
        do_reset();
        wr(3'd1, 8'h01); wr(3'd0, 8'd3);
        repeat (40) @(negedge clk);
        check("R8 snapshot zero busy", chk_busy, 1);
        check("R8 snapshot zero no err", chk_timeout_err, 0);

        // R8: periodic keeps snapshot 3 despite larger later timeout
        do_reset();
        wr(3'd0, 8'd3); wr(3'd1, 8'h01); wr(3'd0, 8'd40);
        repeat (20) @(negedge clk);
        check("R8 snapshot three err", chk_timeout_err, 1);

        // R9 R10 R11 locks
        do_reset();
        wr(3'd0, 8'd9);
        check("R9 unlocked write", rd_timeout, 9);
        wr(3'd0, 8'd0);
        wr(3'd4, 8'h00);
        check("R11 chk_lock cleared", rd_chk_lock, 0);
        wr(3'd0, 8'd7); wr(3'd1, 8'h05); wr(3'd2, 8'h06);
        check("R9 timeout locked", rd_timeout, 0);
        check("R9 imask locked", rd_imask, 0);
        check("R9 cmask locked", rd_cmask, 0);
        wr(3'd4, 8'h01);
        check("R11 chk_lock not reset", rd_chk_lock, 0);
        wr(3'd5, 8'h00);
        check("R11 trig_lock cleared", rd_trig_lock, 0);
        wr(3'd3, 8'h03);
        starts = 0;
        repeat (40) begin @(negedge clk); if (chk_start) starts++; end
        check("R10 trigger ignored", starts, 0);
        wr(3'd5, 8'h01);
        check("R11 trig_lock not reset", rd_trig_lock, 0);

        finish_run();
    end

    logic [DW-1:0] sweep_masks [6] = '{8'h01, 8'h02, 8'h03, 8'h05, 8'h07, 8'h80};
endmodule